// File: doc/BRIEF.md
# Fixed 2x Bilinear Interpolation Datapath

This block is the arithmetic core of a 2x image upscaler. Each accepted cycle it receives a vertical pair of source pixels for the current column: the upper-row pixel on `top_i` and the lower-row pixel on `bot_i`. It also receives a two-bit interpolation kind and two edge flags. It keeps the pair from the previous accepted cycle in a small internal column bank. From these four pixels it produces one output pixel: the original pixel, the mean of two pixels, or the mean of four. Because the interpolation weights are limited to 0 and one half, the datapath contains only adders and fixed right shifts, with no multipliers.

The surrounding sequencer owns line-buffer addressing. It steps through the output grid and selects the kind for each output pixel. On the final output row it raises `last_row_i`, and on the final output column it raises `last_col_i`. Each flag replaces the missing neighbour by replication of the preceding one. The result is registered once, and `valid_o` tracks `valid_i` with the same one-cycle delay.

Top module: `upscale2x_interp`

## Requirements
- R1: While `rst_ni` is low, and until the first accepted cycle after reset, `valid_o` is 0 and `pix_o` is 0. The column bank also starts at 0.
- R2: Kind 2'b00 (copy): the output is `top_i` of the accepted cycle.
- R3: Kind 2'b01 (horizontal): the output is (P + `top_i`) >> 1. P is the `top_i` of the previous accepted cycle. The sum is formed at PIX_W+1 bits and truncated, with no rounding.
- R4: Kind 2'b10 (vertical): the output is (`top_i` + `bot_i`) >> 1, formed at PIX_W+1 bits and truncated.
- R5: Kind 2'b11 (central): the output is the four-pixel sum >> 2, formed at PIX_W+2 bits so that it cannot overflow. The four pixels are the previous accepted pair and the current pair.
- R6: With `last_row_i` high, the lower row is never used. Vertical becomes copy, and central becomes horizontal.
- R7: With `last_col_i` high, the previous column is never used. Horizontal becomes copy, and central becomes vertical. With both flags high, every kind yields `top_i`.
- R8: Each accepted input gives its result on `pix_o` one clock later, with `valid_o` high. A cycle with `valid_i` low gives `valid_o` low one clock later.
- R9: A cycle with `valid_i` low leaves `pix_o` unchanged. It also does not load the column bank, so the next horizontal or central result still uses the pair from the last accepted cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pair and controls are valid this cycle |
| mode_i | input | 2 | Interpolation kind: 00 copy, 01 horizontal, 10 vertical, 11 central |
| last_row_i | input | 1 | Output pixel lies on the final output row |
| last_col_i | input | 1 | Output pixel lies on the final output column |
| top_i | input | PIX_W | Upper-row source pixel of the current column |
| bot_i | input | PIX_W | Lower-row source pixel of the current column |
| valid_o | output | 1 | `pix_o` holds a new result |
| pix_o | output | PIX_W | Interpolated output pixel |

## Verification
Some properties are checked by assertions on every cycle. These cover the one-cycle valid tracking, the hold of `pix_o` and of the column bank across idle cycles, and exact passthrough in copy mode and when both edge flags are set. They also check that the quad sum never falls below a pair sum, which would indicate a truncated width. The arithmetic of each average, including truncation and the fallback from central to horizontal or vertical at the edges, can only be shown by the bench's scenarios. The bench streams every combination of kind, flags and pixel pair for a narrow pixel width. Idle cycles are interleaved, so the previous-column operand is always the pair from the last accepted cycle.

// File: rtl/upscale2x_pkg.sv
package upscale2x_pkg;
  // bit 0 requests the horizontal neighbour, bit 1 the vertical one
  typedef enum logic [1:0] {
    IMODE_COPY = 2'b00,
    IMODE_HORZ = 2'b01,
    IMODE_VERT = 2'b10,
    IMODE_CENT = 2'b11
  } imode_e;
endpackage

// File: rtl/upscale2x_col_bank.sv
module upscale2x_col_bank #(
  parameter int PIX_W = 18,
  parameter int LANES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [LANES-1:0][PIX_W-1:0] cur_i,
  output logic [LANES-1:0][PIX_W-1:0] prev_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     prev_o[g] <= '0;
      else if (load_i) prev_o[g] <= cur_i[g];
    end
  end

  assert_bank_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> prev_o == $past(cur_i));
  assert_bank_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(prev_o));
endmodule

// File: rtl/upscale2x_sums.sv
module upscale2x_sums #(
  parameter int PIX_W = 18
) (
  input  logic [PIX_W-1:0] prev_top_i,
  input  logic [PIX_W-1:0] prev_bot_i,
  input  logic [PIX_W-1:0] cur_top_i,
  input  logic [PIX_W-1:0] cur_bot_i,
  output logic [PIX_W:0]   h_sum_o,
  output logic [PIX_W:0]   v_sum_o,
  output logic [PIX_W+1:0] q_sum_o
);
  localparam int PW = PIX_W + 1;
  localparam int QW = PIX_W + 2;

  logic [PW-1:0] b_sum;

  // quad reuses the upper and lower horizontal pairs
  always_comb begin
    h_sum_o = PW'(prev_top_i) + PW'(cur_top_i);
    b_sum   = PW'(prev_bot_i) + PW'(cur_bot_i);
    v_sum_o = PW'(cur_top_i)  + PW'(cur_bot_i);
    q_sum_o = QW'(h_sum_o)    + QW'(b_sum);
  end

  always_comb begin
    assert_quad_wide_R5: assert (q_sum_o >= QW'(h_sum_o) && q_sum_o >= QW'(b_sum));
  end
endmodule

// File: rtl/upscale2x_pick.sv
module upscale2x_pick
  import upscale2x_pkg::*;
#(
  parameter int PIX_W = 18
) (
  input  imode_e           mode_i,
  input  logic             last_row_i,
  input  logic             last_col_i,
  input  logic [PIX_W-1:0] cur_top_i,
  input  logic [PIX_W:0]   h_sum_i,
  input  logic [PIX_W:0]   v_sum_i,
  input  logic [PIX_W+1:0] q_sum_i,
  output logic [PIX_W-1:0] pix_o
);
  logic use_h, use_v;

  // edge flags drop the missing neighbour (replication)
  always_comb begin
    use_h = mode_i[0] & ~last_col_i;
    use_v = mode_i[1] & ~last_row_i;
    unique case ({use_v, use_h})
      2'b01:   pix_o = h_sum_i[PIX_W:1];
      2'b10:   pix_o = v_sum_i[PIX_W:1];
      2'b11:   pix_o = q_sum_i[PIX_W+1:2];
      default: pix_o = cur_top_i;
    endcase
  end
endmodule

// File: rtl/upscale2x_interp.sv
module upscale2x_interp
  import upscale2x_pkg::*;
#(
  parameter int PIX_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       mode_i,
  input  logic             last_row_i,
  input  logic             last_col_i,
  input  logic [PIX_W-1:0] top_i,
  input  logic [PIX_W-1:0] bot_i,
  output logic             valid_o,
  output logic [PIX_W-1:0] pix_o
);
  localparam int LANES = 2;

  logic [LANES-1:0][PIX_W-1:0] cur_pair, prev_pair;
  logic [PIX_W:0]              h_sum, v_sum;
  logic [PIX_W+1:0]            q_sum;
  logic [PIX_W-1:0]            pix_d;
  imode_e                      mode;

  assign cur_pair[0] = top_i;
  assign cur_pair[1] = bot_i;
  assign mode        = imode_e'(mode_i);

  upscale2x_col_bank #(.PIX_W(PIX_W), .LANES(LANES)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (valid_i),
    .cur_i  (cur_pair),
    .prev_o (prev_pair)
  );

  upscale2x_sums #(.PIX_W(PIX_W)) u_sums (
    .prev_top_i (prev_pair[0]),
    .prev_bot_i (prev_pair[1]),
    .cur_top_i  (top_i),
    .cur_bot_i  (bot_i),
    .h_sum_o    (h_sum),
    .v_sum_o    (v_sum),
    .q_sum_o    (q_sum)
  );

  upscale2x_pick #(.PIX_W(PIX_W)) u_pick (
    .mode_i     (mode),
    .last_row_i (last_row_i),
    .last_col_i (last_col_i),
    .cur_top_i  (top_i),
    .h_sum_i    (h_sum),
    .v_sum_i    (v_sum),
    .q_sum_i    (q_sum),
    .pix_o      (pix_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pix_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) pix_o <= pix_d;
    end
  end

  assert_valid_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pix_o));
  assert_copy_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode == IMODE_COPY) |=> pix_o == $past(top_i));
  assert_corner_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_row_i && last_col_i) |=> pix_o == $past(top_i));
endmodule

// File: tb/upscale2x_interp_tb.sv
module upscale2x_interp_tb;
  localparam int W = 3;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   mode_i = 2'b00;
  logic         last_row_i = 1'b0, last_col_i = 1'b0;
  logic [W-1:0] top_i = '0, bot_i = '0;
  logic         valid_o;
  logic [W-1:0] pix_o;

  int checks = 0, errors = 0;
  int m_pt = 0, m_pb = 0, m_pix = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  upscale2x_interp #(.PIX_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .last_row_i(last_row_i), .last_col_i(last_col_i),
    .top_i(top_i), .bot_i(bot_i), .valid_o(valid_o), .pix_o(pix_o));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string tag(int m, int lr, int lc);
    if (lr != 0 && m[1]) return "R6";
    if (lc != 0 && m[0]) return "R7";
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic int model(int m, int lr, int lc, int t, int b);
    bit h, v;
    h = m[0] && lc == 0;
    v = m[1] && lr == 0;
    if (h && v) return (m_pt + m_pb + t + b) >> 2;
    if (h)      return (m_pt + t) >> 1;
    if (v)      return (t + b) >> 1;
    return t;
  endfunction

  // drive at a negedge, check at the next negedge
  task automatic step(bit v, int m, int lr, int lc, int t, int b);
    string req;
    int exp;
    valid_i = v; mode_i = 2'(m); last_row_i = lr[0]; last_col_i = lc[0];
    top_i = W'(t); bot_i = W'(b);
    exp = v ? model(m, lr, lc, t, b) : m_pix;
    req = v ? tag(m, lr, lc) : "R9";
    @(negedge clk);
    check("R8", int'(valid_o), int'(v));
    check(req, int'(pix_o), exp);
    if (v) begin
      m_pix = exp; m_pt = t; m_pb = b;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(valid_o), 0);
    check("R1", int'(pix_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(pix_o), 0);
    // first horizontal after reset sees a zero bank
    step(1'b1, 1, 0, 0, 6, 1);
    // saturated central must not wrap
    step(1'b1, 0, 0, 0, MAXV, MAXV);
    step(1'b1, 3, 0, 0, MAXV, MAXV);
    // truncation: (1+2)>>1 = 1
    step(1'b1, 0, 0, 0, 1, 0);
    step(1'b1, 2, 0, 0, 1, 2);
    // idle keeps bank: next horizontal uses pair (1,2)
    step(1'b0, 3, 0, 0, 7, 7);
    step(1'b1, 1, 0, 0, 4, 0);
    // both edges force copy
    step(1'b1, 3, 1, 1, 5, 0);
    // full stream with bubbles
    for (int i = 0; i < 8192; i++) begin
      step((i % 7) != 6, (i >> 6) & 3, (i >> 8) & 1, (i >> 9) & 1,
           i & MAXV, ((i >> 3) ^ (i >> 10)) & MAXV);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule